// File: doc/BRIEF.md
# Inter-Processor Byte Mailbox

This block lets a secondary processor exchange single bytes with a host processor. On the secondary side it sits in the I/O space: the lower half of that space is split into four port groups, chosen by the three top address bits. Each group repeats across the 32 addresses it covers. One group holds the byte going to the host, one holds the byte coming from the host, and one returns a status byte. Reading a status port does not need a separate acknowledge.

Two handshake flags track the exchange. A flag is raised by whichever side fills a byte and dropped when the other side takes it. All of this happens as a side effect of ordinary data-port accesses. The host side is a plain write strobe with a byte for the inbound register, and a read strobe that marks the outbound byte as taken. The outbound byte is always visible to the host.

Top module: `mbox_port`

## Requirements
- R1: Only addresses with bit 7 clear are decoded, and the port group is taken from bits 6:5 (0 = outbound, 1 = inbound, 2 = status, 3 = spare). Bits 4:0 are ignored, so 0x1F acts as 0x00. Accesses with bit 7 set change nothing and read as 0x00.
- R2: A secondary write to group 0 loads the outbound byte, which appears on `host_rdata` after that clock edge, and raises the pending-to-host flag.
- R3: A secondary read of group 0 returns the outbound byte and leaves both flags unchanged.
- R4: A secondary read of group 1 returns the inbound byte and drops the from-host-available flag at that clock edge.
- R5: A secondary read of group 2 returns the status byte: bit 7 is the from-host-available flag, bit 0 is the pending-to-host flag, and bits 6:1 are 0.
- R6: A host write strobe loads the inbound byte and raises the from-host-available flag.
- R7: A host read strobe drops the pending-to-host flag.
- R8: If one edge both raises and drops a flag, the flag ends up raised. A read of group 1 in the same cycle as a host write returns the byte that was held before that edge.
- R9: While `rst_n` is low, both flags and both bytes are 0. After `rst_n` rises, the block stays in reset for two more rising clock edges.
- R10: Reads of group 3 return 0x00. Writes to groups 1, 2 and 3 change neither byte nor either flag.
- R11: `sec_rdata` is 0x00 whenever `sec_rd` is low. It follows the addressed port combinationally while `sec_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_rd | input | 1 | Secondary I/O read strobe, one access per cycle high |
| sec_wr | input | 1 | Secondary I/O write strobe, one access per cycle high |
| sec_addr | input | 8 | Secondary I/O address |
| sec_wdata | input | 8 | Secondary write data |
| sec_rdata | output | 8 | Secondary read data |
| host_wr | input | 1 | Host strobe that loads the inbound byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host strobe that marks the outbound byte taken |
| host_rdata | output | 8 | Current outbound byte |

## Verification
The bench targets the cycles where both sides touch the same flag at once. If clear were given priority over set, a byte loaded while the host acknowledges the previous one would be lost and its pending flag would read 0. Aliased addresses such as 0x1F and 0x3F are tried, because a decoder that looks at more than the top three bits would miss them. Upper-half addresses are tried as well, because a decoder that ignores bit 7 would corrupt the outbound byte. The bench also reads the outbound port and then checks status, since a decoder that treats every data read as an acknowledge would drop the pending flag on that read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    GRP_OUTB = 2'd0,
    GRP_INB  = 2'd1,
    GRP_STAT = 2'd2,
    GRP_SPARE = 2'd3
  } mbox_grp_e;

  typedef struct packed {
    logic wr_outb;
    logic rd_outb;
    logic rd_inb;
    logic rd_stat;
  } mbox_hit_t;

  localparam int FLG_PEND  = 0;
  localparam int FLG_AVAIL = 1;
  localparam int NUM_FLG   = 2;

endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
(
  input  logic       rd,
  input  logic       wr,
  input  logic [2:0] top_bits,
  output mbox_hit_t  hit
);
  logic      lower_half;
  mbox_grp_e grp;

  always_comb begin
    lower_half  = ~top_bits[2];
    grp         = mbox_grp_e'(top_bits[1:0]);
    hit         = '0;
    hit.wr_outb = wr & lower_half & (grp == GRP_OUTB);
    hit.rd_outb = rd & lower_half & (grp == GRP_OUTB);
    hit.rd_inb  = rd & lower_half & (grp == GRP_INB);
    hit.rd_stat = rd & lower_half & (grp == GRP_STAT);
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set | clr;
    q_d  = set ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/mbox_byte_reg.sv
module mbox_byte_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb begin
    q_d = load ? din : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_rd,
  input  logic          sec_wr,
  input  logic [AW-1:0] sec_addr,
  input  logic [DW-1:0] sec_wdata,
  output logic [DW-1:0] sec_rdata,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata
);
  localparam int STAT_AVAIL_BIT = DW - 1;
  localparam int STAT_PEND_BIT  = 0;
  localparam int SEL_LSB        = AW - 3;

  logic                rst_sync_n;
  mbox_hit_t           hit;
  logic [NUM_FLG-1:0]  flg_set;
  logic [NUM_FLG-1:0]  flg_clr;
  logic [NUM_FLG-1:0]  flag_q;
  logic [DW-1:0]       outb_q;
  logic [DW-1:0]       inb_q;
  logic [DW-1:0]       stat_byte;
  logic                unused_addr_bits;

  assign unused_addr_bits = ^sec_addr[SEL_LSB-1:0];

  mbox_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbox_decode u_dec (
    .rd       (sec_rd),
    .wr       (sec_wr),
    .top_bits (sec_addr[AW-1:SEL_LSB]),
    .hit      (hit)
  );

  mbox_byte_reg #(.DW(DW)) u_outb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (hit.wr_outb),
    .din   (sec_wdata),
    .q     (outb_q)
  );

  mbox_byte_reg #(.DW(DW)) u_inb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (host_wr),
    .din   (host_wdata),
    .q     (inb_q)
  );

  always_comb begin
    flg_set            = '0;
    flg_clr            = '0;
    flg_set[FLG_PEND]  = hit.wr_outb;
    flg_clr[FLG_PEND]  = host_rd;
    flg_set[FLG_AVAIL] = host_wr;
    flg_clr[FLG_AVAIL] = hit.rd_inb;
  end

  for (genvar g = 0; g < NUM_FLG; g++) begin : g_flag
    mbox_flag u_flag (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set   (flg_set[g]),
      .clr   (flg_clr[g]),
      .q     (flag_q[g])
    );
  end

  always_comb begin
    stat_byte                 = '0;
    stat_byte[STAT_AVAIL_BIT] = flag_q[FLG_AVAIL];
    stat_byte[STAT_PEND_BIT]  = flag_q[FLG_PEND];
  end

  always_comb begin
    sec_rdata = '0;
    if (hit.rd_outb)      sec_rdata = outb_q;
    else if (hit.rd_inb)  sec_rdata = inb_q;
    else if (hit.rd_stat) sec_rdata = stat_byte;
  end

  assign host_rdata = outb_q;
endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          sec_rd,
  input logic          sec_wr,
  input logic [AW-1:0] sec_addr,
  input logic [DW-1:0] sec_wdata,
  input logic [DW-1:0] sec_rdata,
  input logic          host_wr,
  input logic [DW-1:0] host_wdata,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic [1:0]    flag_q,
  input logic [DW-1:0] inb_q
);
  logic [2:0] sel;
  assign sel = sec_addr[AW-1 -: 3];

  // R2
  outb_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_wr && sel == 3'b000) |=> (host_rdata == $past(sec_wdata) && flag_q[0]));

  // R3
  outb_read_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_rd && sel == 3'b000 && !host_rd && !host_wr) |=> (flag_q == $past(flag_q)));

  // R4
  inb_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_rd && sel == 3'b001 && !host_wr) |=> !flag_q[1]);

  // R5
  stat_layout_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_rd && sel == 3'b010) |-> (sec_rdata[DW-2:1] == '0 &&
      sec_rdata[DW-1] == flag_q[1] && sec_rdata[0] == flag_q[0]));

  // R6
  host_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_wr |=> (flag_q[1] && inb_q == $past(host_wdata)));

  // R7
  host_take_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && !(sec_wr && sel == 3'b000)) |=> !flag_q[0]);

  // R8
  pend_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && sec_wr && sel == 3'b000) |=> flag_q[0]);

  // R9
  reset_release_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (flag_q == 2'b00 && host_rdata == '0));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sec_rd |-> (sec_rdata == '0));

  // R10
  upper_or_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_rd && (sel[2] || sel == 3'b011)) |-> (sec_rdata == '0));
endmodule

bind mbox_port mbox_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sec_rd     (sec_rd),
  .sec_wr     (sec_wr),
  .sec_addr   (sec_addr),
  .sec_wdata  (sec_wdata),
  .sec_rdata  (sec_rdata),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .flag_q     (flag_q),
  .inb_q      (inb_q)
);

// File: tb/tb_mbox_port.sv
module tb_mbox_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_rd, sec_wr, host_wr, host_rd;
  logic [7:0] sec_addr, sec_wdata, host_wdata;
  logic [7:0] sec_rdata, host_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  mbox_port dut (
    .clk(clk), .rst_n(rst_n), .sec_rd(sec_rd), .sec_wr(sec_wr),
    .sec_addr(sec_addr), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    sec_rd = 0; sec_wr = 0; host_wr = 0; host_rd = 0;
    sec_addr = 8'h00; sec_wdata = 8'h00; host_wdata = 8'h00;
  endtask

  task automatic sec_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sec_wr = 1; sec_addr = a; sec_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic sec_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sec_rd = 1; sec_addr = a;
    #1 d = sec_rdata;
    @(negedge clk); idle();
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic host_take();
    @(negedge clk); host_rd = 1;
    @(negedge clk); idle();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; #1;
    check("R11 idle rdata", sec_rdata, 8'h00);
    check("R9 outbound in reset", host_rdata, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    sec_read(8'h40, rv); check("R9 status after reset", rv, 8'h00);
  endtask

  task automatic t_outbound();
    sec_write(8'h00, 8'hA5);
    check("R2 host sees byte", host_rdata, 8'hA5);
    sec_read(8'h40, rv); check("R2 R5 pending set", rv, 8'h01);
    sec_read(8'h00, rv); check("R3 readback", rv, 8'hA5);
    sec_read(8'h40, rv); check("R3 flags kept", rv, 8'h01);
    sec_read(8'h1F, rv); check("R1 alias 0x1F", rv, 8'hA5);
    host_take();
    sec_read(8'h40, rv); check("R7 pending cleared", rv, 8'h00);
  endtask

  task automatic t_inbound();
    host_write(8'h3C);
    sec_read(8'h5E, rv); check("R6 R5 available set", rv, 8'h80);
    sec_read(8'h3F, rv); check("R4 inbound byte", rv, 8'h3C);
    sec_read(8'h40, rv); check("R4 available cleared", rv, 8'h00);
    host_write(8'h11);
    sec_write(8'h07, 8'h22);
    sec_read(8'h40, rv); check("R5 both flags", rv, 8'h81);
    host_take();
    sec_read(8'h20, rv); check("R4 second byte", rv, 8'h11);
  endtask

  task automatic t_ignored();
    sec_write(8'h80, 8'h55);
    check("R1 upper write ignored", host_rdata, 8'h22);
    sec_read(8'h40, rv); check("R1 upper write flags", rv, 8'h00);
    sec_read(8'h80, rv); check("R1 upper read zero", rv, 8'h00);
    sec_read(8'hC0, rv); check("R1 upper status alias zero", rv, 8'h00);
    sec_write(8'h20, 8'h66);
    sec_write(8'h40, 8'h77);
    sec_write(8'h60, 8'h88);
    check("R10 writes ignored byte", host_rdata, 8'h22);
    sec_read(8'h40, rv); check("R10 writes ignored flags", rv, 8'h00);
    sec_read(8'h20, rv); check("R10 inbound untouched", rv, 8'h11);
    sec_read(8'h60, rv); check("R10 spare reads zero", rv, 8'h00);
  endtask

  task automatic t_priority();
    sec_write(8'h00, 8'h01);
    @(negedge clk); sec_wr = 1; sec_addr = 8'h00; sec_wdata = 8'h9A; host_rd = 1;
    @(negedge clk); idle();
    sec_read(8'h40, rv); check("R8 pending set wins", rv, 8'h01);
    check("R8 new outbound", host_rdata, 8'h9A);
    host_take();
    host_write(8'h44);
    @(negedge clk); sec_rd = 1; sec_addr = 8'h20; host_wr = 1; host_wdata = 8'h55;
    #1 rv = sec_rdata;
    @(negedge clk); idle();
    check("R8 old inbound returned", rv, 8'h44);
    sec_read(8'h40, rv); check("R8 available set wins", rv, 8'h80);
    sec_read(8'h20, rv); check("R8 new inbound", rv, 8'h55);
  endtask

  task automatic t_reset_mid();
    host_write(8'hEE);
    sec_write(8'h00, 8'hDD);
    sec_read(8'h40, rv); check("R9 flags before reset", rv, 8'h81);
    do_reset();
    sec_read(8'h20, rv); check("R9 inbound cleared", rv, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    do_reset();
    t_outbound();
    t_inbound();
    t_ignored();
    t_priority();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule